// File: doc/BRIEF.md
# Reconfigurable LUT Pair with RAM and Shift Modes

This block holds two 16-entry single-bit tables, called LUT A and LUT B, and lets a run-time mode decide what they are. The same two storage words can serve as a pair of independent 4-input combinational function generators. They can also act as synchronous-write distributed RAM in four shapes: two separate 16x1 memories, one 16x2 memory, one 32x1 memory, or a 16x1 memory with a second read port. In the last mode they form a 32-stage serial shift register with variable taps.

A configuration port loads either table as a whole and sets the mode. The data side has two 4-bit address buses, two write data bits, a write/shift enable and a serial input. All reads are combinational from the current addresses. Every write, shift and configuration load takes effect on the rising clock edge.

Top module: `lutpair_cell`

## Requirements
- R1: After the active-low reset, the mode is logic (code 0), both tables hold all zeros, and `out_a_o`, `out_b_o` and `sout_o` are 0.
- R2: `cfg_load_i` writes `cfg_data_i` into LUT A (`cfg_sel_i`=0) or LUT B (`cfg_sel_i`=1) at the clock edge. `cfg_mode_wr_i` loads the mode from `cfg_mode_i` at the clock edge.
- R3: Logic mode (code 0) gives `out_a_o` = A[`addr_a_i`] and `out_b_o` = B[`addr_b_i`], with bit index n being the table entry selected by address n. In this mode `sout_o` is 0.
- R4: In logic mode, `we_i`, `wdata_i` and `sin_i` have no effect on either table.
- R5: Split RAM mode (code 1): when `we_i` is high, A[`addr_a_i`] takes `wdata_i[0]` and B[`addr_b_i`] takes `wdata_i[1]`. Reads are as in R3.
- R6: Wide RAM mode (code 2) uses `addr_a_i` for both tables. A write stores `wdata_i[0]` in A and `wdata_i[1]` in B. `out_a_o` and `out_b_o` read A and B at `addr_a_i`.
- R7: Deep RAM mode (code 3) uses the 5-bit address {`addr_b_i[0]`, `addr_a_i`}. The top bit selects LUT B when 1 and LUT A when 0. Only the selected table takes `wdata_i[0]`. `out_a_o` reads the selected entry and `out_b_o` is 0.
- R8: Dual-port mode (code 4): a write stores `wdata_i[0]` at `addr_a_i` in both tables. `out_a_o` = A[`addr_a_i`] and `out_b_o` = B[`addr_b_i`], so B serves as a read-only mirror.
- R9: Shift mode (code 5): each edge with `we_i` high shifts A up one place with `sin_i` entering bit 0, and shifts B up with A[15] entering B bit 0. `out_a_o` = A[`addr_a_i`] (a tap delay of address+1), `out_b_o` = B[`addr_b_i`], and `sout_o` = B[15].
- R10: Codes 6 and 7 behave exactly as logic mode.
- R11: During a cycle with `cfg_load_i` high, no data write or shift changes either table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load a whole table from the configuration data |
| cfg_sel_i | input | 1 | Table to load: 0 = A, 1 = B |
| cfg_data_i | input | 16 | Table contents for a configuration load |
| cfg_mode_wr_i | input | 1 | Load the mode register |
| cfg_mode_i | input | 3 | Mode code |
| addr_a_i | input | 4 | Address / function inputs of LUT A |
| addr_b_i | input | 4 | Address / function inputs of LUT B |
| wdata_i | input | 2 | Write data bits |
| we_i | input | 1 | Write enable, or shift enable in shift mode |
| sin_i | input | 1 | Serial input in shift mode |
| out_a_o | output | 1 | LUT A read output |
| out_b_o | output | 1 | LUT B read output |
| sout_o | output | 1 | Cascade output (last shift stage) |

## Verification
The bench builds the block with the default `ADDR_W` of 4, so each table has 16 entries. With that size the full 32-stage cascade can be filled and observed at `sout_o` within a few dozen cycles. Every address bit is reached by the table of logic-mode reads. The deep mode's fifth address bit lands on `addr_b_i[0]` at this size, and directed writes check that it selects the table.

// File: rtl/lutpair_pkg.sv
package lutpair_pkg;

    typedef enum logic [2:0] {
        M_LOGIC    = 3'd0,
        M_RAM_SP   = 3'd1,
        M_RAM_WIDE = 3'd2,
        M_RAM_DEEP = 3'd3,
        M_RAM_DUAL = 3'd4,
        M_SHIFT    = 3'd5,
        M_RSV6     = 3'd6,
        M_RSV7     = 3'd7
    } lut_mode_e;

endpackage

// File: rtl/lutpair_mem.sv
// One table: configuration load beats shift, shift beats single-bit write.
module lutpair_mem #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_ld_i,
    input  logic [DEPTH-1:0]  cfg_data_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_bit_i,
    input  logic              sh_en_i,
    input  logic              sh_in_i,
    output logic [DEPTH-1:0]  bits_o
);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } mem_state_t;

    mem_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_ld_i) begin
            s_d.bits = cfg_data_i;
        end else if (sh_en_i) begin
            s_d.bits = {s_q.bits[DEPTH-2:0], sh_in_i};
        end else if (wr_en_i) begin
            s_d.bits[wr_addr_i] = wr_bit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign bits_o = s_q.bits;

    // R2: a load copies the configuration word exactly
    p_cfg_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_ld_i |=> bits_o == $past(cfg_data_i));

    // R9: a shift moves every stage up one and takes the serial bit at stage 0
    p_shift_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sh_en_i && !cfg_ld_i) |=>
            bits_o == {$past(bits_o[DEPTH-2:0]), $past(sh_in_i)});

    // R4: with no request the contents stay put
    p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_ld_i && !sh_en_i && !wr_en_i) |=> $stable(bits_o));

endmodule

// File: rtl/lutpair_wr_ctrl.sv
// Steers the data-side write and shift requests to each table by mode.
module lutpair_wr_ctrl
    import lutpair_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  lut_mode_e                 mode_i,
    input  logic                      cfg_busy_i,
    input  logic                      we_i,
    input  logic [1:0]                wdata_i,
    input  logic                      sin_i,
    input  logic [ADDR_W-1:0]         addr_a_i,
    input  logic [ADDR_W-1:0]         addr_b_i,
    input  logic                      a_msb_i,
    output logic [1:0]                wr_en_o,
    output logic [1:0][ADDR_W-1:0]    wr_addr_o,
    output logic [1:0]                wr_bit_o,
    output logic [1:0]                sh_en_o,
    output logic [1:0]                sh_in_o
);

    always_comb begin
        wr_en_o      = '0;
        wr_addr_o[0] = addr_a_i;
        wr_addr_o[1] = addr_b_i;
        wr_bit_o     = wdata_i;
        sh_en_o      = '0;
        sh_in_o      = {a_msb_i, sin_i};
        unique case (mode_i)
            M_RAM_SP: begin
                wr_en_o = {we_i, we_i};
            end
            M_RAM_WIDE: begin
                wr_en_o      = {we_i, we_i};
                wr_addr_o[1] = addr_a_i;
            end
            M_RAM_DEEP: begin
                wr_en_o      = {we_i & addr_b_i[0], we_i & ~addr_b_i[0]};
                wr_addr_o[1] = addr_a_i;
                wr_bit_o     = {wdata_i[0], wdata_i[0]};
            end
            M_RAM_DUAL: begin
                wr_en_o      = {we_i, we_i};
                wr_addr_o[1] = addr_a_i;
                wr_bit_o     = {wdata_i[0], wdata_i[0]};
            end
            M_SHIFT: begin
                sh_en_o = {we_i, we_i};
            end
            default: begin
            end
        endcase
        if (cfg_busy_i) begin
            wr_en_o = '0;
            sh_en_o = '0;
        end
    end

endmodule

// File: rtl/lutpair_rdmux.sv
// Combinational read selection for both outputs and the cascade tap.
module lutpair_rdmux
    import lutpair_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  lut_mode_e              mode_i,
    input  logic [1:0][DEPTH-1:0]  lut_bits_i,
    input  logic [ADDR_W-1:0]      addr_a_i,
    input  logic [ADDR_W-1:0]      addr_b_i,
    output logic                   out_a_o,
    output logic                   out_b_o,
    output logic                   sout_o
);

    always_comb begin
        out_a_o = lut_bits_i[0][addr_a_i];
        out_b_o = lut_bits_i[1][addr_b_i];
        sout_o  = 1'b0;
        unique case (mode_i)
            M_RAM_WIDE: begin
                out_b_o = lut_bits_i[1][addr_a_i];
            end
            M_RAM_DEEP: begin
                out_a_o = addr_b_i[0] ? lut_bits_i[1][addr_a_i]
                                      : lut_bits_i[0][addr_a_i];
                out_b_o = 1'b0;
            end
            M_SHIFT: begin
                sout_o = lut_bits_i[1][DEPTH-1];
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/lutpair_cell.sv
module lutpair_cell
    import lutpair_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_load_i,
    input  logic              cfg_sel_i,
    input  logic [DEPTH-1:0]  cfg_data_i,
    input  logic              cfg_mode_wr_i,
    input  logic [2:0]        cfg_mode_i,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    input  logic [1:0]        wdata_i,
    input  logic              we_i,
    input  logic              sin_i,
    output logic              out_a_o,
    output logic              out_b_o,
    output logic              sout_o
);

    typedef struct packed {
        lut_mode_e mode;
    } cell_state_t;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_mode_wr_i) st_d.mode = lut_mode_e'(cfg_mode_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: M_LOGIC};
        else         st_q <= st_d;
    end

    logic [1:0]              wr_en;
    logic [1:0][ADDR_W-1:0]  wr_addr;
    logic [1:0]              wr_bit;
    logic [1:0]              sh_en;
    logic [1:0]              sh_in;
    logic [1:0][DEPTH-1:0]   lut_bits;

    lutpair_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr_ctrl (
        .mode_i     (st_q.mode),
        .cfg_busy_i (cfg_load_i),
        .we_i       (we_i),
        .wdata_i    (wdata_i),
        .sin_i      (sin_i),
        .addr_a_i   (addr_a_i),
        .addr_b_i   (addr_b_i),
        .a_msb_i    (lut_bits[0][DEPTH-1]),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_bit_o   (wr_bit),
        .sh_en_o    (sh_en),
        .sh_in_o    (sh_in)
    );

    for (genvar k = 0; k < 2; k++) begin : g_lut
        lutpair_mem #(.ADDR_W(ADDR_W)) u_mem (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cfg_ld_i   (cfg_load_i && (cfg_sel_i == 1'(k))),
            .cfg_data_i (cfg_data_i),
            .wr_en_i    (wr_en[k]),
            .wr_addr_i  (wr_addr[k]),
            .wr_bit_i   (wr_bit[k]),
            .sh_en_i    (sh_en[k]),
            .sh_in_i    (sh_in[k]),
            .bits_o     (lut_bits[k])
        );
    end

    lutpair_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .mode_i     (st_q.mode),
        .lut_bits_i (lut_bits),
        .addr_a_i   (addr_a_i),
        .addr_b_i   (addr_b_i),
        .out_a_o    (out_a_o),
        .out_b_o    (out_b_o),
        .sout_o     (sout_o)
    );

    // R4 and R10: logic and reserved codes freeze both tables unless loaded
    p_logic_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.mode inside {M_LOGIC, M_RSV6, M_RSV7}) && !cfg_load_i)
            |=> $stable(lut_bits));

    // R8: after a dual-port write both tables agree at the written address
    p_dual_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == M_RAM_DUAL && we_i && !cfg_load_i && !cfg_mode_wr_i) |=>
            lut_bits[0][$past(addr_a_i)] == lut_bits[1][$past(addr_a_i)]);

    // R7: the deep shape never writes both tables in one cycle
    p_deep_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == M_RAM_DEEP) |-> $onehot0(wr_en));

    // R11: a configuration load suppresses every data-side request
    p_cfg_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_load_i |-> (wr_en == 2'b00 && sh_en == 2'b00));

    // R3: the cascade output is quiet outside shift mode
    p_sout_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode != M_SHIFT) |-> !sout_o);

endmodule

// File: tb/lutpair_cell_tb_top.sv
module lutpair_cell_tb_top;

    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam logic [DEPTH-1:0] CFG_A = 16'hA5C3;
    localparam logic [DEPTH-1:0] CFG_B = 16'h0F96;
    localparam int NVEC = 8;
    // each entry: {addr_a, addr_b}
    localparam logic [7:0] RD_VEC [NVEC] =
        '{8'h00, 8'h2F, 8'h6A, 8'h93, 8'hC5, 8'hF1, 8'h4E, 8'hB8};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic           cfg_load, cfg_sel, cfg_mode_wr;
    logic [DEPTH-1:0] cfg_data;
    logic [2:0]     cfg_mode;
    logic [AW-1:0]  addr_a, addr_b;
    logic [1:0]     wdata;
    logic           we, sin;
    logic           out_a, out_b, sout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    lutpair_cell #(.ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_load_i(cfg_load), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
        .cfg_mode_wr_i(cfg_mode_wr), .cfg_mode_i(cfg_mode),
        .addr_a_i(addr_a), .addr_b_i(addr_b), .wdata_i(wdata),
        .we_i(we), .sin_i(sin),
        .out_a_o(out_a), .out_b_o(out_b), .sout_o(sout)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic [2:0] m);
        cfg_mode_wr = 1'b1; cfg_mode = m;
        tick();
        cfg_mode_wr = 1'b0;
    endtask

    task automatic load(input logic s, input logic [DEPTH-1:0] d);
        cfg_load = 1'b1; cfg_sel = s; cfg_data = d;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [AW-1:0] b);
        addr_a = a; addr_b = b;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_load = 0; cfg_sel = 0; cfg_mode_wr = 0;
        cfg_data = '0; cfg_mode = 3'd0; addr_a = 4'd5; addr_b = 4'd9;
        wdata = 2'b00; we = 0; sin = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 out_a", out_a, 1'b0);
        chk("R1 out_b", out_b, 1'b0);
        chk("R1 sout", sout, 1'b0);

        // R2 + R3: load both tables, walk the read vectors in logic mode
        load(1'b0, CFG_A);
        load(1'b1, CFG_B);
        for (int i = 0; i < NVEC; i++) begin
            rd(RD_VEC[i][7:4], RD_VEC[i][3:0]);
            chk("R3 out_a", out_a, CFG_A[RD_VEC[i][7:4]]);
            chk("R3 out_b", out_b, CFG_B[RD_VEC[i][3:0]]);
            chk("R3 sout", sout, 1'b0);
        end

        // R4: write and shift inputs ignored in logic mode
        rd(4'd2, 4'd0);
        we = 1; wdata = 2'b11; sin = 1;
        tick(); tick();
        we = 0; sin = 0;
        rd(4'd2, 4'd0);
        chk("R4 out_a", out_a, 1'b0);
        chk("R4 out_b", out_b, 1'b0);

        // R5: split RAM, independent addresses
        set_mode(3'd1);
        rd(4'd2, 4'd3); we = 1; wdata = 2'b11;
        tick(); we = 0;
        rd(4'd2, 4'd3);
        chk("R5 out_a", out_a, 1'b1);
        chk("R5 out_b", out_b, 1'b1);
        rd(4'd3, 4'd3);
        chk("R5 neighbour", out_a, 1'b0);

        // R6: wide RAM, shared address addr_a
        set_mode(3'd2);
        rd(4'd4, 4'd9); we = 1; wdata = 2'b01;
        tick(); we = 0;
        rd(4'd4, 4'd9);
        chk("R6 out_a", out_a, 1'b1);
        chk("R6 out_b", out_b, 1'b0);

        // R7: deep RAM, addr_b[0] selects table B
        set_mode(3'd3);
        rd(4'd5, 4'd1); we = 1; wdata = 2'b01;
        tick(); we = 0;
        rd(4'd5, 4'd1);
        chk("R7 upper", out_a, 1'b1);
        chk("R7 out_b", out_b, 1'b0);
        rd(4'd5, 4'd0);
        chk("R7 lower", out_a, 1'b0);

        // R8: dual port, both tables written at addr_a
        set_mode(3'd4);
        rd(4'd7, 4'd8); we = 1; wdata = 2'b00;
        tick(); we = 0;
        rd(4'd7, 4'd7);
        chk("R8 out_a", out_a, 1'b0);
        chk("R8 mirror", out_b, 1'b0);
        rd(4'd7, 4'd8);
        chk("R8 port b", out_b, 1'b1);

        // R10: reserved code behaves as logic mode
        set_mode(3'd6);
        rd(4'd5, 4'd0); we = 1; wdata = 2'b11; sin = 1;
        tick(); tick();
        we = 0; sin = 0;
        rd(4'd5, 4'd0);
        chk("R10 out_a", out_a, 1'b0);
        chk("R10 out_b", out_b, 1'b0);

        // R9: 32-stage shift with taps and cascade
        set_mode(3'd5);
        load(1'b0, '0);
        load(1'b1, '0);
        we = 1; sin = 1;
        tick();
        sin = 0;
        rd(4'd0, 4'd0);
        chk("R9 tap1", out_a, 1'b1);
        repeat (3) tick();
        rd(4'd3, 4'd0);
        chk("R9 tap4", out_a, 1'b1);
        rd(4'd2, 4'd0);
        chk("R9 tap3", out_a, 1'b0);
        repeat (27) tick();
        rd(4'd0, 4'd14);
        chk("R9 cascade b", out_b, 1'b1);
        chk("R9 sout early", sout, 1'b0);
        tick();
        we = 0;
        chk("R9 sout", sout, 1'b1);

        // R11: configuration load blocks shift in the same cycle
        cfg_load = 1; cfg_sel = 0; cfg_data = 16'h0002; we = 1; sin = 1;
        tick();
        cfg_load = 0; we = 0; sin = 0;
        rd(4'd0, 4'd15);
        chk("R11 a0", out_a, 1'b0);
        rd(4'd1, 4'd15);
        chk("R11 a1", out_a, 1'b1);
        chk("R11 b hold", out_b, 1'b1);
        chk("R11 sout", sout, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule